// File: doc/BRIEF.md
# Three-Level Configuration Strap Reader

This block tells, from one board strap pin, which of three charging arrangements the board is wired for. It does this once, during bring-up and before charging is allowed. The pin can be tied high, tied low, or left unconnected. A plain logic read cannot tell an unconnected pin from a tied one. The block therefore tests the pin twice. It first turns on a weak internal pull toward the supply and waits a settling window. It then turns on a weak pull toward ground for a window of the same length. At the end of each window it takes one reading of the pin through a synchronizer.

A pin that reads the same under both pulls is being driven from outside. A pin that reads high under the upward pull and low under the downward pull is floating. The pair of readings is mapped to a mode code, and the code is held until the next reset. A tied-high strap selects parallel charging, a tied-low strap selects two-cell series charging, and an open strap selects single-cell charging. After the test both pulls are released and the done flag stays high.

The block moves no data stream, so it has no valid/ready handshake. The start input, the two pull enables, the done flag and the mode code are plain level signals. None of them can be stalled, and the block applies no back-pressure.

Top module: `strap_sense`

## Requirements
- R1: While reset is held and right after it is released, both pull enables are low, done is low and the mode output is 2'b00.
- R2: A start pulse received while idle asserts the upward pull first, for exactly SETTLE cycles. The downward pull follows at once, for exactly SETTLE cycles. SETTLE values below 3 are raised to 3.
- R3: The upward and downward pull enables are never high in the same cycle.
- R4: A pin that reads high at the end of both windows gives mode 2'b11, which is parallel charging.
- R5: A pin that reads low at the end of both windows gives mode 2'b10, which is two-cell series charging.
- R6: A pin that reads high under the upward pull and low under the downward pull is open, and gives mode 2'b01, which is single-cell charging.
- R7: A contradictory pair (low under the upward pull, high under the downward pull) also gives mode 2'b01.
- R8: Done rises in the cycle after the downward window ends, with both pulls low. After that, done and the mode hold until reset, even if start pulses or the pin changes.
- R9: The mode output reads 2'b00 whenever done is low.
- R10: A start pulse during a test in progress neither restarts nor lengthens either window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the strap test |
| pin_i | input | 1 | Raw strap pin level, asynchronous |
| pull_up_en_o | output | 1 | Enables the weak pull toward the supply |
| pull_dn_en_o | output | 1 | Enables the weak pull toward ground |
| mode_o | output | 2 | Detected mode: 00 none, 01 single cell, 10 two-cell series, 11 parallel |
| done_o | output | 1 | High once the mode is valid, until reset |

## Verification
Each kind of internal fault shows up at a specific port. If the phase sequencer is in the wrong state, the pull enables have the wrong order, overlap, or last the wrong length, and the bench sees this within one window of the start pulse. If the window counter is wrong, the count of cycles each pull is high is off by the fault's amount. If the captured first reading or the classification is wrong, mode_o holds a wrong code from the cycle done rises. A sequencer that does not lock after the test shows pull activity or a changed code on a later start pulse.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_UP   = 2'b01,
    PH_DN   = 2'b10,
    PH_DONE = 2'b11
  } phase_t;

  typedef enum logic [1:0] {
    MODE_NONE     = 2'b00,
    MODE_SINGLE   = 2'b01,
    MODE_SERIES   = 2'b10,
    MODE_PARALLEL = 2'b11
  } mode_t;

  // Map the two end-of-window readings to a charging mode.
  function automatic mode_t classify(input logic rd_under_up, input logic rd_under_dn);
    mode_t m;
    case ({rd_under_up, rd_under_dn})
      2'b11:   m = MODE_PARALLEL;
      2'b00:   m = MODE_SERIES;
      default: m = MODE_SINGLE;   // follows the pull, or contradictory
    endcase
    return m;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= 1'b0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic last_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST_V = CW'(WINDOW - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!active_i)         cnt <= '0;
    else if (cnt == LAST_V)     cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign last_o = active_i && (cnt == LAST_V);

  // R2: window count never runs past its final value
  assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_V);

  // R2: counter is back at zero whenever no window is open
  assert_cnt_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active_i) |-> cnt == '0);
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic active_o,
  output logic pull_up_o,
  output logic pull_dn_o,
  output logic cap_up_o,
  output logic cap_dn_o,
  output logic done_o
);
  phase_t ph, ph_nx;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE: if (start_i) ph_nx = PH_UP;
      PH_UP:   if (last_i)  ph_nx = PH_DN;
      PH_DN:   if (last_i)  ph_nx = PH_DONE;
      default: ph_nx = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nx;
  end

  assign pull_up_o = (ph == PH_UP);
  assign pull_dn_o = (ph == PH_DN);
  assign active_o  = pull_up_o || pull_dn_o;
  assign cap_up_o  = pull_up_o && last_i;
  assign cap_dn_o  = pull_dn_o && last_i;
  assign done_o    = (ph == PH_DONE);

  // R3: opposite pulls never overlap
  assert_pulls_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_up_o && pull_dn_o));

  // R2: the downward pull only ever starts straight after the upward one
  assert_up_then_dn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_dn_o) |-> $past(pull_up_o));

  // R8: done is sticky until reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R10: a running window is not disturbed by start
  assert_start_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_dn_o && !last_i) |=> pull_dn_o);
endmodule

// File: rtl/strap_classify.sv
module strap_classify
  import strap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_i,
  input  logic  cap_up_i,
  input  logic  cap_dn_i,
  output mode_t mode_o
);
  logic  rd_up_q;
  mode_t mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_up_q <= 1'b0;
      mode_q  <= MODE_NONE;
    end else begin
      if (cap_up_i) rd_up_q <= sample_i;
      if (cap_dn_i) mode_q  <= classify(rd_up_q, sample_i);
    end
  end

  assign mode_o = mode_q;

  // R4..R7: a code is written only at the end of the downward window
  assert_mode_write_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_NONE) |=> $stable(mode_q));
endmodule

// File: rtl/strap_sense.sv
module strap_sense
  import strap_pkg::*;
#(
  parameter int SETTLE      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pin_i,
  output logic       pull_up_en_o,
  output logic       pull_dn_en_o,
  output logic [1:0] mode_o,
  output logic       done_o
);
  // R2: the synchronizer needs the window to outlast its latency
  localparam int WINDOW = (SETTLE < SYNC_STAGES + 1) ? (SYNC_STAGES + 1) : SETTLE;

  logic  pin_s, active, last, cap_up, cap_dn;
  mode_t mode_w;

  strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  strap_timer #(.WINDOW(WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .active_i(active), .last_o(last)
  );

  strap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last),
    .active_o(active), .pull_up_o(pull_up_en_o), .pull_dn_o(pull_dn_en_o),
    .cap_up_o(cap_up), .cap_dn_o(cap_dn), .done_o(done_o)
  );

  strap_classify u_cls (
    .clk(clk), .rst_n(rst_n), .sample_i(pin_s),
    .cap_up_i(cap_up), .cap_dn_i(cap_dn), .mode_o(mode_w)
  );

  assign mode_o = mode_w;

  // R9: no code is shown before the test completes
  assert_mode_hidden_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> mode_o == 2'b00);

  // R8: pulls released and code valid once done
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!pull_up_en_o && !pull_dn_en_o && mode_o != 2'b00));

  // R8: mode frozen after done
  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(mode_o));
endmodule

// File: tb/sim_strap_sense.sv
`timescale 1ns/1ps
module sim_strap_sense;
  localparam int SETTLE = 5;
  localparam logic [1:0] K_HIGH = 2'd0, K_LOW = 2'd1, K_OPEN = 2'd2, K_CONTRA = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic pin;
  logic [1:0] kind = K_OPEN;
  logic pu, pd, done;
  logic [1:0] mode;

  int n_chk = 0, n_bad = 0;
  int up_n, dn_n, both_n, first_pull, mode_early;

  always #2 clk = ~clk;

  // board model of the strap
  always_comb begin
    case (kind)
      K_HIGH:  pin = 1'b1;
      K_LOW:   pin = 1'b0;
      K_OPEN:  pin = pu;
      default: pin = pd;
    endcase
  end

  strap_sense #(.SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pin_i(pin),
    .pull_up_en_o(pu), .pull_dn_en_o(pd), .mode_o(mode), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic [1:0] k, input int kick_at);
    kind = k;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    up_n = 0; dn_n = 0; both_n = 0; first_pull = 0; mode_early = 0;
    for (int i = 0; i < 200 && !done; i++) begin
      if (pu) up_n++;
      if (pd) dn_n++;
      if (pu && pd) both_n++;
      if (first_pull == 0 && pu) first_pull = 1;
      if (first_pull == 0 && pd) first_pull = 2;
      if (mode != 2'b00) mode_early++;
      start = (i == kick_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic check_run(input string req, input int exp_mode);
    chk("R2 upward window length", up_n, SETTLE);
    chk("R2 downward window length", dn_n, SETTLE);
    chk("R2 upward pull first", first_pull, 1);
    chk("R3 pulls overlap", both_n, 0);
    chk("R9 mode shown early", mode_early, 0);
    chk("R8 done set", int'(done), 1);
    chk("R8 pulls released", int'(pu) + int'(pd), 0);
    chk(req, int'(mode), exp_mode);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pull up in reset", int'(pu), 0);
    chk("R1 pull down in reset", int'(pd), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 mode after reset", int'(mode), 0);
    chk("R1 pulls idle without start", int'(pu) + int'(pd), 0);
  endtask

  task automatic t_high();   do_reset(); run(K_HIGH, -1);   check_run("R4 tied high mode", 3); endtask
  task automatic t_low();    do_reset(); run(K_LOW, -1);    check_run("R5 tied low mode", 2);  endtask
  task automatic t_open();   do_reset(); run(K_OPEN, -1);   check_run("R6 open mode", 1);      endtask
  task automatic t_contra(); do_reset(); run(K_CONTRA, -1); check_run("R7 contradictory mode", 1); endtask

  task automatic t_locked();
    int pulls = 0;
    do_reset(); run(K_LOW, -1);
    kind = K_HIGH;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3 * SETTLE; i++) begin
      if (pu || pd) pulls++;
      @(negedge clk);
    end
    chk("R8 no pull after done", pulls, 0);
    chk("R8 mode held after done", int'(mode), 2);
    chk("R8 done held", int'(done), 1);
  endtask

  task automatic t_restart();
    do_reset(); run(K_HIGH, 3);
    chk("R10 upward window with extra start", up_n, SETTLE);
    chk("R10 downward window with extra start", dn_n, SETTLE);
    chk("R10 mode with extra start", int'(mode), 3);
    do_reset(); run(K_OPEN, SETTLE + 1);
    chk("R10 upward window, start in second window", up_n, SETTLE);
    chk("R10 downward window, start in second window", dn_n, SETTLE);
  endtask

  task automatic t_reset_clears();
    do_reset();
    chk("R1 reset clears mode", int'(mode), 0);
    chk("R1 reset clears done", int'(done), 0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_high();
    t_low();
    t_open();
    t_contra();
    t_locked();
    t_restart();
    t_reset_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule